// File: doc/BRIEF.md
# Peak-Hold Amplitude Envelope Tracker

This block follows the amplitude of a signed sample stream. Every sample that arrives with a strobe is turned into a saturated magnitude. The block keeps the last three magnitudes. A magnitude that is strictly larger than both of its neighbours marks a peak, and that peak value is kept in a hold register. No smoothing filter is used. The envelope is therefore a chain of straight holds between local maxima.

Before the envelope is output, a guard stage takes the larger of the held peak and the magnitude under decision. It then adds a small positive floor constant and clips the result at full scale. A peak can only be confirmed once the following sample is known, so each decision is made one strobe after its sample arrives. A small controller counts the first two strobes after reset so that no envelope is produced before the window holds a real sample.

The controller has three states. EMPTY means no sample has been seen since reset. PRIMED means one sample is in the window. TRACK means decisions are flowing. The transitions are:
- EMPTY to PRIMED on the first strobe.
- PRIMED to TRACK on the second strobe.
- TRACK stays in TRACK.
- Each state stays where it is on a cycle without a strobe.

Top module: `env_tracker`

## Requirements
- R1: After reset, `env_out` reads 0, and the magnitude history and the held peak are cleared to 0.
- R2: The magnitude of a sample is its absolute value. The most negative code (-2^(DATA_W-1)) maps to the largest magnitude 2^(DATA_W-1)-1, which is called full scale (FS).
- R3: The middle magnitude of the window is a peak only when it is strictly greater than both the older and the newer magnitude. Equal neighbours, such as a plateau, do not make a peak.
- R4: When the middle magnitude is not a peak, the held peak keeps its previous value.
- R5: Each envelope value is at least the magnitude under decision, which is the sample that arrived one strobe earlier.
- R6: The envelope equals max(held peak, magnitude under decision) + THRESH, clipped to FS. THRESH defaults to 1.
- R7: `env_out` changes only on a clock edge where `in_valid` is 1. Cycles without a strobe leave it unchanged, whatever `in_sample` carries.
- R8: The first strobe after reset only loads the window, and `env_out` stays 0. The second strobe produces the first envelope value, in the same cycle edge.
- R9: The controller moves EMPTY to PRIMED to TRACK, one step per strobe, and never moves backward until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | DATA_W | Signed two's-complement sample |
| env_out | output | DATA_W-1 | Unsigned envelope, registered |

## Verification
A wrong internal state in this block shows up in `env_out` within one or two strobes:
- If the held peak is corrupted, the output carries that value (plus THRESH) at the next strobe whose magnitude under decision is smaller than the held value.
- If the window is shifted wrongly, the peak decisions land on the wrong sample. The effect appears one strobe later, for example as a plateau value being held.
- If the controller is off by one state, the first envelope value appears one strobe early or late.

The reference model predicts `env_out` after every clock and compares it to the design, so any of these faults is caught at the first strobe where it becomes visible.

// File: rtl/env_pkg.sv
package env_pkg;
    // Fill level of the three-magnitude window after reset
    typedef enum logic [1:0] {
        ST_EMPTY  = 2'd0,
        ST_PRIMED = 2'd1,
        ST_TRACK  = 2'd2
    } env_state_e;
endpackage

// File: rtl/env_mag.sv
module env_mag #(
    parameter int DATA_W = 8,
    parameter int MAG_W  = DATA_W - 1
) (
    input  logic signed [DATA_W-1:0] x_i,
    output logic        [MAG_W-1:0]  mag_o
);
    localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};

    logic [DATA_W-1:0] negated;

    always_comb begin
        negated = -x_i;
        if (x_i == MOST_NEG) begin
            mag_o = '1;                      // saturate
        end else if (x_i[DATA_W-1]) begin
            mag_o = negated[MAG_W-1:0];
        end else begin
            mag_o = x_i[MAG_W-1:0];
        end
    end

    always_comb begin
        if (!x_i[DATA_W-1]) begin
            AST_MAG_POS_PASS: assert (mag_o == x_i[MAG_W-1:0]); // R2
        end
    end
endmodule

// File: rtl/env_window.sv
module env_window #(
    parameter int MAG_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_i,
    input  logic [MAG_W-1:0] new_i,
    output logic [MAG_W-1:0] old_q,
    output logic [MAG_W-1:0] mid_q,
    output logic             peak_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            old_q <= '0;
            mid_q <= '0;
        end else if (shift_i) begin
            old_q <= mid_q;
            mid_q <= new_i;
        end
    end

    // Strict comparison on both sides of the middle tap
    always_comb peak_o = (mid_q > old_q) && (mid_q > new_i);

    AST_WIN_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        shift_i |=> old_q == $past(mid_q)); // R3
endmodule

// File: rtl/env_hold.sv
module env_hold #(
    parameter int MAG_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [MAG_W-1:0] d_i,
    output logic [MAG_W-1:0] q_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_o <= '0;
        else if (load_i) q_o <= d_i;
    end

    AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(q_o)); // R4
endmodule

// File: rtl/env_out_stage.sv
module env_out_stage #(
    parameter int MAG_W  = 7,
    parameter int THRESH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [MAG_W-1:0] held_i,
    input  logic [MAG_W-1:0] cur_i,
    output logic [MAG_W-1:0] env_q
);
    localparam logic [MAG_W:0] FS    = {1'b0, {MAG_W{1'b1}}};
    localparam logic [MAG_W:0] THR_W = (MAG_W + 1)'(THRESH);

    logic [MAG_W-1:0] larger;
    logic [MAG_W:0]   sum;
    logic [MAG_W-1:0] env_d;

    always_comb begin
        larger = (held_i > cur_i) ? held_i : cur_i;
        sum    = {1'b0, larger} + THR_W;
        env_d  = (sum > FS) ? FS[MAG_W-1:0] : sum[MAG_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) env_q <= '0;
        else if (en_i) env_q <= env_d;
    end

    AST_ENV_ABOVE_MAG: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |=> env_q >= $past(cur_i)); // R5
    AST_ENV_ABOVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |=> env_q >= $past(held_i)); // R6
endmodule

// File: rtl/env_tracker.sv
module env_tracker #(
    parameter int DATA_W = 8,
    parameter int THRESH = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_sample,
    output logic [DATA_W-2:0] env_out
);
    import env_pkg::*;

    localparam int MAG_W = DATA_W - 1;

    env_state_e       state_q, state_d;
    logic [MAG_W-1:0] mag_new, old_mag, mid_mag, hold_q, held_next;
    logic             peak, decide;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // Next state and control outputs
    always_comb begin
        state_d = state_q;
        decide  = 1'b0;
        unique case (state_q)
            ST_EMPTY:  if (in_valid) state_d = ST_PRIMED;
            ST_PRIMED: if (in_valid) begin
                           state_d = ST_TRACK;
                           decide  = 1'b1;
                       end
            ST_TRACK:  decide = in_valid;
            default:   state_d = ST_EMPTY;
        endcase
        held_next = peak ? mid_mag : hold_q;
    end

    env_mag #(.DATA_W(DATA_W), .MAG_W(MAG_W)) mag_i (
        .x_i   (in_sample),
        .mag_o (mag_new)
    );

    env_window #(.MAG_W(MAG_W)) win_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .shift_i(in_valid),
        .new_i  (mag_new),
        .old_q  (old_mag),
        .mid_q  (mid_mag),
        .peak_o (peak)
    );

    env_hold #(.MAG_W(MAG_W)) hold_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load_i(decide && peak),
        .d_i   (mid_mag),
        .q_o   (hold_q)
    );

    env_out_stage #(.MAG_W(MAG_W), .THRESH(THRESH)) out_i (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (decide),
        .held_i(held_next),
        .cur_i (mid_mag),
        .env_q (env_out)
    );

    AST_ENV_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(env_out)); // R7
    AST_FIRST_NO_ENV: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_EMPTY |=> env_out == '0); // R8
    AST_FSM_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_TRACK |=> state_q == ST_TRACK); // R9
    AST_FSM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EMPTY && in_valid) |=> state_q == ST_PRIMED); // R9
endmodule

// File: tb/env_tracker_tb.sv
`timescale 1ns/1ps
module env_tracker_tb_top;
    localparam int DATA_W = 8;
    localparam int FS     = 127;
    localparam int THR    = 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [DATA_W-1:0] in_sample = '0;
    logic [DATA_W-2:0] env_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    // reference model state
    int m_old, m_mid, m_hold, m_env, m_count;

    always #4 clk = ~clk;

    env_tracker #(.DATA_W(DATA_W), .THRESH(THR)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_sample(in_sample),
        .env_out  (env_out)
    );

    function automatic int mag_of(int x);
        if (x == -128) return FS;
        return (x < 0) ? -x : x;
    endfunction

    task automatic check(input string tag);
        n_checks++;
        if (int'(env_out) !== m_env) begin
            n_fail++;
            $display("FAIL %s: env_out actual=%0d expected=%0d", tag, env_out, m_env);
        end
    endtask

    task automatic model_reset();
        m_old = 0; m_mid = 0; m_hold = 0; m_env = 0; m_count = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0;
        model_reset();
        repeat (2) @(negedge clk);
        check("R1 reset");
        rst_n = 1'b1;
    endtask

    // Drive one cycle; model the edge; compare 2 ns after the edge
    task automatic step(input bit v, input int x, input string tag);
        int m, big, e;
        @(negedge clk);
        in_valid  = v;
        in_sample = x[DATA_W-1:0];
        @(posedge clk);
        if (v) begin
            m = mag_of(x);
            if (m_count > 0) begin
                if (m_mid > m_old && m_mid > m) m_hold = m_mid;
                big = (m_hold > m_mid) ? m_hold : m_mid;
                e = big + THR;
                m_env = (e > FS) ? FS : e;
            end
            m_old = m_mid;
            m_mid = m;
            m_count++;
        end
        #2;
        check(tag);
    endtask

    initial begin
        model_reset();
        do_reset();
        // R8: first strobe only loads window
        step(1, 50, "R8 first strobe");
        step(0, 99, "R7 idle");
        // R3 peak 30 between 10 and 20 (after 50 also)
        step(1, 10, "R8 second strobe");
        step(1, 30, "R3");
        step(1, 20, "R3 peak confirmed");
        // R4 falling after peak keeps hold
        step(1, 5, "R4");
        step(1, 3, "R4");
        step(1, 2, "R4");
        // R5 rising ramp, no peak
        for (int i = 4; i < 40; i += 6) step(1, i, "R5 ramp");
        // R3 plateau not a peak
        do_reset();
        step(1, 20, "R8");
        step(1, 40, "R3 plateau");
        step(1, 40, "R3 plateau");
        step(1, 10, "R3 plateau");
        step(1, 5, "R3 plateau");
        step(1, 1, "R4 plateau hold");
        // R2 negative samples and most negative code
        step(1, -60, "R2");
        step(1, -5, "R2");
        step(1, -128, "R2 most negative");
        step(1, -3, "R2");
        step(1, 0, "R6 saturation");
        step(1, 0, "R6 hold at FS");
        step(1, 127, "R6");
        step(1, 126, "R6");
        // R7 idle cycles with junk on the sample input
        for (int i = 0; i < 6; i++) step(0, -100 + i * 37, "R7 idle");
        // R9 reset mid-run and restart
        do_reset();
        step(0, 77, "R9 empty idle");
        step(1, 9, "R9 to primed");
        step(0, 3, "R9 primed idle");
        step(1, 2, "R9 to track");
        step(1, 0, "R9 track");
        // mixed random traffic
        for (int i = 0; i < 400; i++)
            step(($urandom % 4) != 0, int'($urandom % 256) - 128, "R6 random");
        for (int i = 0; i < 200; i++)
            step(1, int'($urandom % 9) - 4, "R6 small random");
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule